// File: doc/BRIEF.md
# Fixed-Format RISC Instruction Decoder

This block takes one 32-bit instruction word from a compact load/store RISC subset and turns it, with no clock and no state, into the control bundle a single-issue datapath consumes in the same cycle. It presents the two source register specifiers, the register to be written, an immediate already extended to 32 bits, an ALU operation code, register-write and memory read/write enables, a byte-versus-word flag, and the kind of branch or jump.

The subset covers three-register arithmetic and compare (add, sub, slt), register jump (jr), immediate arithmetic and logic (addi, slti, andi, ori), load-upper (lui), word and byte loads and stores, equal/not-equal branches, and absolute jumps with and without link. Anything outside that set is flagged as illegal. In that case every write and memory enable is held low, so the surrounding pipeline can trap without side effects.

The decoder sits between the fetch register and the operand-read stage. Its outputs depend only on the current `instr_i`.

Top module: `instr_decoder`

## Requirements
- R1: `rs_idx_o` always equals bits 25:21 of the instruction and `rt_idx_o` always equals bits 20:16, whatever the opcode, including illegal words.
- R2: With opcode 0, funct 32, 34 or 42 select ALU codes ADD=1, SUB=2 or SLT=3 respectively. The register write goes to the rd field (bits 15:11), and the immediate output is 0.
- R3: Opcode 0 with funct 8 gives jump kind REGISTER=2 with no register write, no memory access and ALU code NOP=0.
- R4: addi (opcode 8) and slti (opcode 10) sign-extend bits 15:0 and use ALU codes ADD=1 and SLT=3. andi (12) and ori (13) zero-extend bits 15:0 and use AND=4 and OR=5. All four write the rt register.
- R5: lui (opcode 15) produces an immediate of bits 15:0 followed by sixteen zeros, uses ALU code PASSB=6, and writes rt.
- R6: lw (opcode 35) and lb (opcode 32) assert the memory read, write rt, sign-extend the offset, and use ALU code ADD=1. The byte flag is 1 for lb only.
- R7: sw (opcode 43) and sb (opcode 40) assert the memory write and sign-extend the offset. They use ALU code ADD=1, write no register, and raise the byte flag for sb only.
- R8: beq (opcode 4) and bne (opcode 5) give branch kinds EQ=1 and NE=2. Both use ALU code SUB=2, sign-extend the offset and write no register.
- R9: j (opcode 2) and jal (opcode 3) give jump kind TARGET=1, and the immediate output is the zero-extended 26-bit target field. jal also writes register 31 with ALU code LINK=7. j writes nothing and uses NOP=0.
- R10: Any opcode outside {0,2,3,4,5,8,10,12,13,15,32,35,40,43}, or opcode 0 with a funct outside {8,32,34,42}, raises `illegal_o`. It also zeroes the register write, both memory enables, the byte flag, the branch and jump kinds, the ALU code, the immediate and the destination.
- R11: Whenever `reg_we_o` is 0, `wr_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs_idx_o | output | 5 | First source register specifier |
| rt_idx_o | output | 5 | Second source register specifier |
| wr_idx_o | output | 5 | Register to write (0 when none) |
| imm_o | output | 32 | Extended immediate or jump target |
| alu_op_o | output | 3 | ALU operation code |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| mem_byte_o | output | 1 | 1 = byte access, 0 = word access |
| br_kind_o | output | 2 | Branch kind: 0 none, 1 equal, 2 not equal |
| jmp_kind_o | output | 2 | Jump kind: 0 none, 1 target, 2 register |
| illegal_o | output | 1 | Instruction outside the supported subset |

## Verification
The embedded assertions check, for every word the decoder sees, the invariants between its parts. An illegal word leaves every enable and the immediate at zero. Without a register write the destination is zero. Stores never write a register, and loads always write rt. The logical immediates have a clear upper half, and lui has a clear lower half. A link jump targets register 31. The exact encodings need the bench's vector table and its sweeps: the immediate values, the ALU codes per instruction, the byte flag, and which of the 64 opcodes and 64 funct values are accepted.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

    localparam int ILEN = 32;
    localparam int XLEN = 32;
    localparam int OPW  = 6;
    localparam int FNW  = 6;
    localparam int REGW = 5;
    localparam int IMMW = 16;
    localparam int TGTW = 26;
    localparam int SHW  = 5;

    localparam logic [REGW-1:0] LINK_REG = REGW'(31);
    localparam logic [REGW-1:0] NO_REG   = '0;

    typedef logic [OPW-1:0] opc_t;
    typedef logic [FNW-1:0] fn_t;

    localparam opc_t OP_REGOPS = 6'd0;
    localparam opc_t OP_J      = 6'd2;
    localparam opc_t OP_JAL    = 6'd3;
    localparam opc_t OP_BEQ    = 6'd4;
    localparam opc_t OP_BNE    = 6'd5;
    localparam opc_t OP_ADDI   = 6'd8;
    localparam opc_t OP_SLTI   = 6'd10;
    localparam opc_t OP_ANDI   = 6'd12;
    localparam opc_t OP_ORI    = 6'd13;
    localparam opc_t OP_LUI    = 6'd15;
    localparam opc_t OP_LB     = 6'd32;
    localparam opc_t OP_LW     = 6'd35;
    localparam opc_t OP_SB     = 6'd40;
    localparam opc_t OP_SW     = 6'd43;

    localparam fn_t FN_JR  = 6'd8;
    localparam fn_t FN_ADD = 6'd32;
    localparam fn_t FN_SUB = 6'd34;
    localparam fn_t FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_NOP   = 3'd0,
        ALU_ADD   = 3'd1,
        ALU_SUB   = 3'd2,
        ALU_SLT   = 3'd3,
        ALU_AND   = 3'd4,
        ALU_OR    = 3'd5,
        ALU_PASSB = 3'd6,
        ALU_LINK  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_NE   = 2'd2
    } br_e;

    typedef enum logic [1:0] {
        JMP_NONE   = 2'd0,
        JMP_TARGET = 2'd1,
        JMP_REG    = 2'd2
    } jmp_e;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_RD   = 2'd1,
        DST_RT   = 2'd2,
        DST_LINK = 2'd3
    } dst_e;

    typedef enum logic [2:0] {
        IMM_ZERO  = 3'd0,
        IMM_SEXT  = 3'd1,
        IMM_ZEXT  = 3'd2,
        IMM_UPPER = 3'd3,
        IMM_TGT   = 3'd4
    } imm_e;

    typedef struct packed {
        opc_t            op;
        logic [REGW-1:0] rs;
        logic [REGW-1:0] rt;
        logic [REGW-1:0] rd;
        logic [SHW-1:0]  sh;
        fn_t             fn;
        logic [IMMW-1:0] imm;
        logic [TGTW-1:0] tgt;
    } fields_t;

    typedef struct packed {
        alu_op_e alu;
        logic    mem_rd;
        logic    mem_wr;
        logic    byte_acc;
        br_e     br;
        jmp_e    jmp;
        dst_e    dst;
        imm_e    imm;
        logic    illegal;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        alu:      ALU_NOP,
        mem_rd:   1'b0,
        mem_wr:   1'b0,
        byte_acc: 1'b0,
        br:       BR_NONE,
        jmp:      JMP_NONE,
        dst:      DST_NONE,
        imm:      IMM_ZERO,
        illegal:  1'b0
    };

    function automatic fields_t split_instr(input logic [ILEN-1:0] w);
        fields_t f;
        f.op  = w[31:26];
        f.rs  = w[25:21];
        f.rt  = w[20:16];
        f.rd  = w[15:11];
        f.sh  = w[10:6];
        f.fn  = w[5:0];
        f.imm = w[IMMW-1:0];
        f.tgt = w[TGTW-1:0];
        return f;
    endfunction

endpackage

// File: rtl/rdec_ctrl.sv
module rdec_ctrl
    import rdec_pkg::*;
(
    input  opc_t  op_i,
    input  fn_t   fn_i,
    output ctrl_t ctrl_o
);

    ctrl_t c;

    always_comb begin
        c = CTRL_IDLE;
        unique case (op_i)
            OP_REGOPS: begin
                unique case (fn_i)
                    FN_ADD: begin c.alu = ALU_ADD; c.dst = DST_RD; end
                    FN_SUB: begin c.alu = ALU_SUB; c.dst = DST_RD; end
                    FN_SLT: begin c.alu = ALU_SLT; c.dst = DST_RD; end
                    FN_JR:  begin c.jmp = JMP_REG; end
                    default: c.illegal = 1'b1;
                endcase
            end
            OP_ADDI: begin c.alu = ALU_ADD;   c.dst = DST_RT; c.imm = IMM_SEXT;  end
            OP_SLTI: begin c.alu = ALU_SLT;   c.dst = DST_RT; c.imm = IMM_SEXT;  end
            OP_ANDI: begin c.alu = ALU_AND;   c.dst = DST_RT; c.imm = IMM_ZEXT;  end
            OP_ORI:  begin c.alu = ALU_OR;    c.dst = DST_RT; c.imm = IMM_ZEXT;  end
            OP_LUI:  begin c.alu = ALU_PASSB; c.dst = DST_RT; c.imm = IMM_UPPER; end
            OP_LW, OP_LB: begin
                c.alu      = ALU_ADD;
                c.dst      = DST_RT;
                c.imm      = IMM_SEXT;
                c.mem_rd   = 1'b1;
                c.byte_acc = (op_i == OP_LB);
            end
            OP_SW, OP_SB: begin
                c.alu      = ALU_ADD;
                c.imm      = IMM_SEXT;
                c.mem_wr   = 1'b1;
                c.byte_acc = (op_i == OP_SB);
            end
            OP_BEQ: begin c.alu = ALU_SUB; c.imm = IMM_SEXT; c.br = BR_EQ; end
            OP_BNE: begin c.alu = ALU_SUB; c.imm = IMM_SEXT; c.br = BR_NE; end
            OP_J:   begin c.jmp = JMP_TARGET; c.imm = IMM_TGT; end
            OP_JAL: begin
                c.jmp = JMP_TARGET;
                c.imm = IMM_TGT;
                c.alu = ALU_LINK;
                c.dst = DST_LINK;
            end
            default: c.illegal = 1'b1;
        endcase
    end

    assign ctrl_o = c;

endmodule

// File: rtl/rdec_imm.sv
module rdec_imm
    import rdec_pkg::*;
(
    input  imm_e             mode_i,
    input  logic [IMMW-1:0]  imm_i,
    input  logic [TGTW-1:0]  tgt_i,
    output logic [XLEN-1:0]  val_o
);

    localparam int SEXT_PAD = XLEN - IMMW;
    localparam int TGT_PAD  = XLEN - TGTW;

    always_comb begin
        unique case (mode_i)
            IMM_SEXT:  val_o = {{SEXT_PAD{imm_i[IMMW-1]}}, imm_i};
            IMM_ZEXT:  val_o = {{SEXT_PAD{1'b0}}, imm_i};
            IMM_UPPER: val_o = {imm_i, {SEXT_PAD{1'b0}}};
            IMM_TGT:   val_o = {{TGT_PAD{1'b0}}, tgt_i};
            default:   val_o = '0;
        endcase
    end

endmodule

// File: rtl/rdec_dest.sv
module rdec_dest
    import rdec_pkg::*;
(
    input  dst_e             sel_i,
    input  logic             illegal_i,
    input  logic [REGW-1:0]  rt_i,
    input  logic [REGW-1:0]  rd_i,
    output logic [REGW-1:0]  idx_o,
    output logic             we_o
);

    always_comb begin
        idx_o = NO_REG;
        we_o  = 1'b0;
        if (!illegal_i) begin
            unique case (sel_i)
                DST_RD:   begin idx_o = rd_i;     we_o = 1'b1; end
                DST_RT:   begin idx_o = rt_i;     we_o = 1'b1; end
                DST_LINK: begin idx_o = LINK_REG; we_o = 1'b1; end
                default:  begin idx_o = NO_REG;   we_o = 1'b0; end
            endcase
        end
    end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import rdec_pkg::*;
(
    input  logic [31:0] instr_i,
    output logic [4:0]  rs_idx_o,
    output logic [4:0]  rt_idx_o,
    output logic [4:0]  wr_idx_o,
    output logic [31:0] imm_o,
    output logic [2:0]  alu_op_o,
    output logic        reg_we_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic        mem_byte_o,
    output logic [1:0]  br_kind_o,
    output logic [1:0]  jmp_kind_o,
    output logic        illegal_o
);

    fields_t fld;
    ctrl_t   ctl;

    assign fld = split_instr(instr_i);

    rdec_ctrl u_ctrl (
        .op_i   (fld.op),
        .fn_i   (fld.fn),
        .ctrl_o (ctl)
    );

    rdec_imm u_imm (
        .mode_i (ctl.imm),
        .imm_i  (fld.imm),
        .tgt_i  (fld.tgt),
        .val_o  (imm_o)
    );

    rdec_dest u_dest (
        .sel_i     (ctl.dst),
        .illegal_i (ctl.illegal),
        .rt_i      (fld.rt),
        .rd_i      (fld.rd),
        .idx_o     (wr_idx_o),
        .we_o      (reg_we_o)
    );

    assign rs_idx_o   = fld.rs;
    assign rt_idx_o   = fld.rt;
    assign alu_op_o   = ctl.alu;
    assign mem_rd_o   = ctl.mem_rd;
    assign mem_wr_o   = ctl.mem_wr;
    assign mem_byte_o = ctl.byte_acc;
    assign br_kind_o  = ctl.br;
    assign jmp_kind_o = ctl.jmp;
    assign illegal_o  = ctl.illegal;

    // Cross-module invariants between the control, immediate and destination logic
    always_comb begin
        if (illegal_o) begin
            p_illegal_quiet_r10: assert (!reg_we_o && !mem_rd_o && !mem_wr_o &&
                                         br_kind_o == 2'd0 && jmp_kind_o == 2'd0 &&
                                         imm_o == 32'd0 && wr_idx_o == 5'd0)
                else $error("illegal word left an enable or value active");
        end
        if (!reg_we_o) begin
            p_no_write_no_dest_r11: assert (wr_idx_o == 5'd0)
                else $error("destination nonzero without a write");
        end
        if (mem_wr_o) begin
            p_store_no_write_r7: assert (!reg_we_o && !mem_rd_o)
                else $error("store also writes a register or reads memory");
        end
        if (mem_rd_o) begin
            p_load_writes_rt_r6: assert (reg_we_o && wr_idx_o == rt_idx_o)
                else $error("load does not target rt");
        end
        if (alu_op_o == ALU_AND || alu_op_o == ALU_OR) begin
            p_zext_upper_clear_r4: assert (imm_o[31:16] == 16'd0)
                else $error("logical immediate has upper bits set");
        end
        if (alu_op_o == ALU_PASSB) begin
            p_upper_low_clear_r5: assert (imm_o[15:0] == 16'd0)
                else $error("load-upper immediate has lower bits set");
        end
        if (jmp_kind_o == JMP_TARGET && reg_we_o) begin
            p_link_dest_r9: assert (wr_idx_o == LINK_REG && alu_op_o == ALU_LINK)
                else $error("link jump not writing the link register");
        end
    end

endmodule

// File: tb/tb_instr_decoder.sv
module tb_instr_decoder;

    localparam time CLK_HALF = 10ns;
    localparam int  WATCHDOG_CYCLES = 20000;
    localparam logic T = 1'b1;
    localparam logic F = 1'b0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_i = 32'h0;
    logic [4:0]  rs_idx_o, rt_idx_o, wr_idx_o;
    logic [31:0] imm_o;
    logic [2:0]  alu_op_o;
    logic        reg_we_o, mem_rd_o, mem_wr_o, mem_byte_o, illegal_o;
    logic [1:0]  br_kind_o, jmp_kind_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    instr_decoder dut (
        .instr_i    (instr_i),
        .rs_idx_o   (rs_idx_o),
        .rt_idx_o   (rt_idx_o),
        .wr_idx_o   (wr_idx_o),
        .imm_o      (imm_o),
        .alu_op_o   (alu_op_o),
        .reg_we_o   (reg_we_o),
        .mem_rd_o   (mem_rd_o),
        .mem_wr_o   (mem_wr_o),
        .mem_byte_o (mem_byte_o),
        .br_kind_o  (br_kind_o),
        .jmp_kind_o (jmp_kind_o),
        .illegal_o  (illegal_o)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tgt);
        return {op, tgt};
    endfunction

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] ins;
        logic [4:0]  wr;
        logic [31:0] imm;
        logic [2:0]  alu;
        logic        we;
        logic        mrd;
        logic        mwr;
        logic        byt;
        logic [1:0]  br;
        logic [1:0]  jmp;
        logic        ill;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        // R2 add rd=9, rs=17, rt=18
        '{8'd2,  enc_r(5'd17, 5'd18, 5'd9, 6'd32),  5'd9,  32'h0000_0000, 3'd1, T,F,F,F, 2'd0,2'd0, F},
        // R2 sub
        '{8'd2,  enc_r(5'd1, 5'd2, 5'd3, 6'd34),    5'd3,  32'h0000_0000, 3'd2, T,F,F,F, 2'd0,2'd0, F},
        // R2 slt into r31
        '{8'd2,  enc_r(5'd4, 5'd5, 5'd31, 6'd42),   5'd31, 32'h0000_0000, 3'd3, T,F,F,F, 2'd0,2'd0, F},
        // R3 jr with a nonzero rd field that must be ignored
        '{8'd3,  enc_r(5'd31, 5'd0, 5'd7, 6'd8),    5'd0,  32'h0000_0000, 3'd0, F,F,F,F, 2'd0,2'd2, F},
        // R4 addi negative
        '{8'd4,  enc_i(6'd8, 5'd1, 5'd4, 16'hFFFC),  5'd4,  32'hFFFF_FFFC, 3'd1, T,F,F,F, 2'd0,2'd0, F},
        // R4 slti most negative immediate
        '{8'd4,  enc_i(6'd10, 5'd2, 5'd5, 16'h8000), 5'd5,  32'hFFFF_8000, 3'd3, T,F,F,F, 2'd0,2'd0, F},
        // R4 andi all ones stays unsigned
        '{8'd4,  enc_i(6'd12, 5'd3, 5'd6, 16'hFFFF), 5'd6,  32'h0000_FFFF, 3'd4, T,F,F,F, 2'd0,2'd0, F},
        // R4 ori
        '{8'd4,  enc_i(6'd13, 5'd3, 5'd7, 16'h8234), 5'd7,  32'h0000_8234, 3'd5, T,F,F,F, 2'd0,2'd0, F},
        // R5 lui
        '{8'd5,  enc_i(6'd15, 5'd0, 5'd8, 16'hAAAA), 5'd8,  32'hAAAA_0000, 3'd6, T,F,F,F, 2'd0,2'd0, F},
        // R6 lw offset 32
        '{8'd6,  enc_i(6'd35, 5'd18, 5'd9, 16'd32),  5'd9,  32'h0000_0020, 3'd1, T,T,F,F, 2'd0,2'd0, F},
        // R6 lb offset -1
        '{8'd6,  enc_i(6'd32, 5'd4, 5'd10, 16'hFFFF), 5'd10, 32'hFFFF_FFFF, 3'd1, T,T,F,T, 2'd0,2'd0, F},
        // R7 sw
        '{8'd7,  enc_i(6'd43, 5'd29, 5'd11, 16'd4),  5'd0,  32'h0000_0004, 3'd1, F,F,T,F, 2'd0,2'd0, F},
        // R7 sb negative offset
        '{8'd7,  enc_i(6'd40, 5'd5, 5'd12, 16'h8001), 5'd0, 32'hFFFF_8001, 3'd1, F,F,T,T, 2'd0,2'd0, F},
        // R8 beq forward
        '{8'd8,  enc_i(6'd4, 5'd16, 5'd17, 16'd25),  5'd0,  32'h0000_0019, 3'd2, F,F,F,F, 2'd1,2'd0, F},
        // R8 bne backward
        '{8'd8,  enc_i(6'd5, 5'd8, 5'd9, 16'hFFFE),  5'd0,  32'hFFFF_FFFE, 3'd2, F,F,F,F, 2'd2,2'd0, F},
        // R9 j all-ones target
        '{8'd9,  enc_j(6'd2, 26'h3FF_FFFF),          5'd0,  32'h03FF_FFFF, 3'd0, F,F,F,F, 2'd0,2'd1, F},
        // R9 jal
        '{8'd9,  enc_j(6'd3, 26'd2500),              5'd31, 32'h0000_09C4, 3'd7, T,F,F,F, 2'd0,2'd1, F},
        // R10 opcode 0 funct 33 (neighbour of add)
        '{8'd10, enc_r(5'd1, 5'd2, 5'd3, 6'd33),    5'd0,  32'h0000_0000, 3'd0, F,F,F,F, 2'd0,2'd0, T},
        // R10 opcode 9 (neighbour of addi)
        '{8'd10, enc_i(6'd9, 5'd1, 5'd2, 16'hFFFF), 5'd0,  32'h0000_0000, 3'd0, F,F,F,F, 2'd0,2'd0, T},
        // R10 opcode 36 (between lw and sb)
        '{8'd10, enc_i(6'd36, 5'd1, 5'd2, 16'h0010), 5'd0, 32'h0000_0000, 3'd0, F,F,F,F, 2'd0,2'd0, T},
        // R10 opcode 63
        '{8'd10, 32'hFFFF_FFFF,                     5'd0,  32'h0000_0000, 3'd0, F,F,F,F, 2'd0,2'd0, T},
        // R10 opcode 1
        '{8'd10, enc_i(6'd1, 5'd3, 5'd1, 16'h0004), 5'd0,  32'h0000_0000, 3'd0, F,F,F,F, 2'd0,2'd0, T}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h (instr %h)", tag, what, got, exp, instr_i);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(posedge clk);
        instr_i <= w;
        @(negedge clk);
    endtask

    task automatic check_quiet(input string tag);
        check(tag, "reg_we",   {31'd0, reg_we_o},   32'd0);
        check(tag, "mem_rd",   {31'd0, mem_rd_o},   32'd0);
        check(tag, "mem_wr",   {31'd0, mem_wr_o},   32'd0);
        check(tag, "mem_byte", {31'd0, mem_byte_o}, 32'd0);
        check(tag, "br_kind",  {30'd0, br_kind_o},  32'd0);
        check(tag, "jmp_kind", {30'd0, jmp_kind_o}, 32'd0);
        check(tag, "alu_op",   {29'd0, alu_op_o},   32'd0);
        check(tag, "imm",      imm_o,               32'd0);
        check(tag, "wr_idx",   {27'd0, wr_idx_o},   32'd0);
    endtask

    function automatic bit op_in_subset(input logic [5:0] op);
        return op inside {6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd10, 6'd12,
                          6'd13, 6'd15, 6'd32, 6'd35, 6'd40, 6'd43};
    endfunction

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        @(negedge clk);

        // Reset state: an all-zero word is opcode 0 funct 0, outside the subset (R10)
        check("R10", "illegal at reset", {31'd0, illegal_o}, 32'd1);
        check_quiet("R10");
        check("R1", "rs at reset", {27'd0, rs_idx_o}, 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            string tag;
            apply(VEC[i].ins);
            tag = $sformatf("R%0d", VEC[i].req);
            check("R1", "rs_idx", {27'd0, rs_idx_o}, {27'd0, VEC[i].ins[25:21]});
            check("R1", "rt_idx", {27'd0, rt_idx_o}, {27'd0, VEC[i].ins[20:16]});
            check(tag, "wr_idx",   {27'd0, wr_idx_o},   {27'd0, VEC[i].wr});
            check(tag, "imm",      imm_o,               VEC[i].imm);
            check(tag, "alu_op",   {29'd0, alu_op_o},   {29'd0, VEC[i].alu});
            check(tag, "reg_we",   {31'd0, reg_we_o},   {31'd0, VEC[i].we});
            check(tag, "mem_rd",   {31'd0, mem_rd_o},   {31'd0, VEC[i].mrd});
            check(tag, "mem_wr",   {31'd0, mem_wr_o},   {31'd0, VEC[i].mwr});
            check(tag, "mem_byte", {31'd0, mem_byte_o}, {31'd0, VEC[i].byt});
            check(tag, "br_kind",  {30'd0, br_kind_o},  {30'd0, VEC[i].br});
            check(tag, "jmp_kind", {30'd0, jmp_kind_o}, {30'd0, VEC[i].jmp});
            check(tag, "illegal",  {31'd0, illegal_o},  {31'd0, VEC[i].ill});
            if (!VEC[i].we)
                check("R11", "wr_idx without write", {27'd0, wr_idx_o}, 32'd0);
        end

        // R10 opcode sweep: funct fixed at 32 so opcode 0 is legal
        for (int op = 0; op < 64; op++) begin
            logic [5:0] o;
            o = 6'(op);
            apply({o, 5'd7, 5'd9, 5'd11, 5'd0, 6'd32});
            check("R10", "opcode sweep illegal", {31'd0, illegal_o}, {31'd0, ~op_in_subset(o)});
            if (!op_in_subset(o))
                check_quiet("R10");
            if (!reg_we_o)
                check("R11", "sweep wr_idx", {27'd0, wr_idx_o}, 32'd0);
        end

        // R10 funct sweep under opcode 0: only 8, 32, 34, 42 are accepted
        for (int fn = 0; fn < 64; fn++) begin
            logic [5:0] f;
            bit ok;
            f = 6'(fn);
            ok = f inside {6'd8, 6'd32, 6'd34, 6'd42};
            apply({6'd0, 5'd3, 5'd4, 5'd5, 5'd0, f});
            check("R10", "funct sweep illegal", {31'd0, illegal_o}, {31'd0, ~ok});
            if (!ok)
                check_quiet("R10");
        end

        // R9 jal link destination does not follow the rd or rt bits of the target
        apply(enc_j(6'd3, 26'h000_4820));
        check("R9", "jal wr_idx", {27'd0, wr_idx_o}, 32'd31);
        check("R9", "jal imm", imm_o, 32'h0000_4820);

        // R6 load destination is rt even when rd bits differ
        apply(enc_i(6'd35, 5'd1, 5'd2, 16'h1800));
        check("R6", "lw dest is rt", {27'd0, wr_idx_o}, 32'd2);
        check("R6", "lw positive offset", imm_o, 32'h0000_1800);

        // R5 lui with zero immediate
        apply(enc_i(6'd15, 5'd9, 5'd30, 16'h0000));
        check("R5", "lui zero imm", imm_o, 32'h0000_0000);
        check("R5", "lui writes", {31'd0, reg_we_o}, 32'd1);

        // R4 andi with sign bit clear
        apply(enc_i(6'd12, 5'd9, 5'd1, 16'h7FFF));
        check("R4", "andi imm", imm_o, 32'h0000_7FFF);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule